// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block converts a single PWM command into two gate commands for a half-bridge, one for the high-side transistor and one for the low-side transistor. The high-side gate follows the PWM command directly. The low-side gate follows its inverse. The two gates are never raised at the same time. Before raising either gate, the sequencer waits for feedback that the opposite transistor has actually switched off. It then waits a further programmable number of clock cycles. The feedback comes from two digitized comparator flags: one says that the switch node has fallen below its threshold, and the other says that the low-side gate has fallen below its threshold.

Three conditions force both gates low: a low enable, a deasserted supply-good flag, or an asserted over-temperature flag. When all of them release, the sequencer does not jump straight back to a gate-on state. It repeats the full off-confirmation and delay first. Every input passes through a two-flop synchronizer before the state machine uses it. A 3-bit phase output reports where the sequencer is. The phase codes are:

| Code | Phase |
|------|-------|
| 0 | forced off |
| 1 | waiting for the switch node to fall |
| 2 | low-side delay |
| 3 | low side on |
| 4 | waiting for the low-side gate to fall |
| 5 | high-side delay |
| 6 | high side on |

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is held and on leaving reset, both gates are low and the phase output is 0.
- R2: Each input passes through two synchronizing flops. A change applied between clock edges therefore alters the phase and gates at the third rising edge after it.
- R3: While enable is low, both gates are low and the phase is 0, whatever the PWM command is.
- R4: While supply-good is low, both gates are low and the phase is 0. The synchronized supply-good flag is low at reset.
- R5: While over-temperature is high, both gates are low and the phase is 0. Normal sequencing resumes only after the flag clears.
- R6: When PWM is low, the phase is 1 and the low-side gate stays low for as long as the synchronized switch-node-low flag is false.
- R7: If the switch-node-low flag is true in phase 1, the next edge enters phase 2. Exactly LS_DLY edges later the low-side gate rises and the phase becomes 3.
- R8: When PWM is high, the phase is 4 and the high-side gate stays low for as long as the synchronized low-side-gate-low flag is false.
- R9: If the low-side-gate-low flag is true in phase 4, the next edge enters phase 5. Exactly HS_DLY edges later the high-side gate rises and the phase becomes 6.
- R10: A PWM reversal during phase 2 or 5 aborts the delay at the edge where the reversal is seen. The sequencer enters the off-confirmation phase for the new direction (4 or 1), and the gate that was pending never rises.
- R11: In no cycle are both gate outputs high.
- R12: After a forced-off condition releases, the sequencer enters phase 4 or 1 before either gate rises. It then completes the full confirmation and delay.
- R13: In steady state the gates are complementary: PWM high gives high side on and low side off, and PWM low gives the opposite.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| pwm_i | input | 1 | PWM command (1 = high side on) |
| en_i | input | 1 | Enable, active high |
| supply_ok_i | input | 1 | Supply-good flag |
| hot_i | input | 1 | Over-temperature flag |
| sw_low_i | input | 1 | Switch node below its threshold |
| lg_low_i | input | 1 | Low-side gate below its threshold |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| phase_o | output | 3 | Current phase code (0..6) |

## Verification
The bench builds the block with LS_DLY = 8 and HS_DLY = 6. With these values both delays stay distinct and a few cycles long. Each gate's rise can be pinned to its exact edge, and a PWM reversal injected three edges into the high-side delay lands while the counter is still nonzero, which exercises the abort path. The switch-node and gate-low flags are driven by hand. This lets the bench hold the node high for a long stretch to show that the low side never rises, and lets it release each forced-off condition while a gate was on.

// File: rtl/gs_pkg.sv
package gs_pkg;
    typedef enum logic [2:0] {
        PH_OFF     = 3'd0,
        PH_WAIT_SW = 3'd1,
        PH_DLY_LS  = 3'd2,
        PH_LS_ON   = 3'd3,
        PH_WAIT_LG = 3'd4,
        PH_DLY_HS  = 3'd5,
        PH_HS_ON   = 3'd6
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   hs;
        logic   ls;
    } seq_st_t;
endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_d, s1_q, s2_d, s2_q;
        always_comb begin
            s1_d = async_i[i];
            s2_d = s1_q;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= s1_d;
                s2_q <= s2_d;
            end
        end
        assign sync_o[i] = s2_q;
    end
endmodule

// File: rtl/gs_dly_cnt.sv
module gs_dly_cnt #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/gs_sequencer.sv
module gs_sequencer
    import gs_pkg::*;
#(
    parameter int unsigned LS_DLY = 11,
    parameter int unsigned HS_DLY = 9,
    parameter int unsigned CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_s,
    input  logic          en_s,
    input  logic          sok_s,
    input  logic          hot_s,
    input  logic          swl_s,
    input  logic          lgl_s,
    input  logic          cnt_zero_i,
    output logic          cnt_load_o,
    output logic [CW-1:0] cnt_val_o,
    output logic          hs_o,
    output logic          ls_o,
    output logic [2:0]    phase_o
);
    localparam logic [CW-1:0] LS_LOAD = CW'(LS_DLY - 1);
    localparam logic [CW-1:0] HS_LOAD = CW'(HS_DLY - 1);

    seq_st_t st_d, st_q;
    logic    force_off;

    always_comb begin
        force_off  = !en_s || !sok_s || hot_s;
        st_d       = st_q;
        cnt_load_o = 1'b0;
        cnt_val_o  = '0;
        if (force_off) begin
            st_d.ph = PH_OFF;
        end else begin
            case (st_q.ph)
                PH_OFF:     st_d.ph = pwm_s ? PH_WAIT_LG : PH_WAIT_SW;
                PH_WAIT_SW: begin
                    if (pwm_s) st_d.ph = PH_WAIT_LG;
                    else if (swl_s) begin
                        st_d.ph    = PH_DLY_LS;
                        cnt_load_o = 1'b1;
                        cnt_val_o  = LS_LOAD;
                    end
                end
                PH_DLY_LS: begin
                    if (pwm_s)           st_d.ph = PH_WAIT_LG;
                    else if (cnt_zero_i) st_d.ph = PH_LS_ON;
                end
                PH_LS_ON:   if (pwm_s) st_d.ph = PH_WAIT_LG;
                PH_WAIT_LG: begin
                    if (!pwm_s) st_d.ph = PH_WAIT_SW;
                    else if (lgl_s) begin
                        st_d.ph    = PH_DLY_HS;
                        cnt_load_o = 1'b1;
                        cnt_val_o  = HS_LOAD;
                    end
                end
                PH_DLY_HS: begin
                    if (!pwm_s)          st_d.ph = PH_WAIT_SW;
                    else if (cnt_zero_i) st_d.ph = PH_HS_ON;
                end
                PH_HS_ON:   if (!pwm_s) st_d.ph = PH_WAIT_SW;
                default:    st_d.ph = PH_OFF;
            endcase
        end
        st_d.hs = (st_d.ph == PH_HS_ON);
        st_d.ls = (st_d.ph == PH_LS_ON);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ph: PH_OFF, hs: 1'b0, ls: 1'b0};
        else        st_q <= st_d;
    end

    assign hs_o    = st_q.hs;
    assign ls_o    = st_q.ls;
    assign phase_o = st_q.ph;

    // R11
    p_gates_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));
    // R3 (also covers R4, R5)
    p_force_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |=> (!hs_o && !ls_o && phase_o == 3'd0));
    // R6
    p_ls_waits_node_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd1 && !swl_s) |=> !ls_o);
    // R7
    p_ls_after_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_o) |-> ($past(phase_o) == 3'd2 && $past(cnt_zero_i)));
    // R9
    p_hs_after_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_o) |-> ($past(phase_o) == 3'd5 && $past(cnt_zero_i)));
    // R10
    p_abort_hs_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'd5 && !pwm_s && !force_off) |=> (phase_o == 3'd1 && !hs_o));
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
    parameter int unsigned LS_DLY = 11,
    parameter int unsigned HS_DLY = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_i,
    input  logic       en_i,
    input  logic       supply_ok_i,
    input  logic       hot_i,
    input  logic       sw_low_i,
    input  logic       lg_low_i,
    output logic       hs_gate_o,
    output logic       ls_gate_o,
    output logic [2:0] phase_o
);
    localparam int unsigned MAXD = (LS_DLY > HS_DLY) ? LS_DLY : HS_DLY;
    localparam int unsigned CW   = $clog2(MAXD + 1);
    localparam int unsigned NIN  = 6;

    logic [NIN-1:0] raw_in, syn;
    logic           cnt_load, cnt_zero;
    logic [CW-1:0]  cnt_val;

    initial begin
        assert (LS_DLY >= 1 && HS_DLY >= 1);
    end

    assign raw_in = {hot_i, lg_low_i, sw_low_i, supply_ok_i, en_i, pwm_i};

    gs_sync #(.W(NIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn)
    );

    gs_dly_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_load),
        .load_val_i(cnt_val), .zero_o(cnt_zero)
    );

    gs_sequencer #(.LS_DLY(LS_DLY), .HS_DLY(HS_DLY), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .pwm_s(syn[0]), .en_s(syn[1]), .sok_s(syn[2]),
        .swl_s(syn[3]), .lgl_s(syn[4]), .hot_s(syn[5]),
        .cnt_zero_i(cnt_zero), .cnt_load_o(cnt_load), .cnt_val_o(cnt_val),
        .hs_o(hs_gate_o), .ls_o(ls_gate_o), .phase_o(phase_o)
    );
endmodule

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;
    localparam int LSD = 8;
    localparam int HSD = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pwm = 1'b1, en = 1'b1, sok = 1'b0, hot = 1'b0, swl = 1'b0, lgl = 1'b1;
    logic hs, ls;
    logic [2:0] ph;

    int n_chk = 0, n_bad = 0;
    bit both_seen = 1'b0;
    bit done = 1'b0;

    typedef struct {
        string    req;
        bit       hs;
        bit       ls;
        bit [2:0] ph;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    hb_gate_seq #(.LS_DLY(LSD), .HS_DLY(HSD)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .en_i(en), .supply_ok_i(sok),
        .hot_i(hot), .sw_low_i(swl), .lg_low_i(lgl),
        .hs_gate_o(hs), .ls_gate_o(ls), .phase_o(ph)
    );

    always @(negedge clk) if (rst_n && hs && ls) both_seen = 1'b1;

    initial begin : monitor
        exp_t e;
        forever begin
            wait (q.size() != 0);
            e = q.pop_front();
            n_chk++;
            if (hs !== e.hs || ls !== e.ls || ph !== e.ph) begin
                n_bad++;
                $display("FAIL %s: actual hs=%0b ls=%0b ph=%0d expected hs=%0b ls=%0b ph=%0d",
                         e.req, hs, ls, ph, e.hs, e.ls, e.ph);
            end
        end
    end

    task automatic expect_st(input string req, input bit h, input bit l, input bit [2:0] p);
        exp_t e;
        e.req = req; e.hs = h; e.ls = l; e.ph = p;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        wait (q.size() == 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : driver
        tick(3);
        expect_st("R1 in reset", 0, 0, 0);
        rst_n = 1'b1;
        tick(1);
        expect_st("R1 after reset", 0, 0, 0);
        tick(10);
        expect_st("R4 supply-good low holds off", 0, 0, 0);

        // supply up with PWM high: confirm low-side gate, then high delay
        sok = 1'b1;
        tick(2);
        expect_st("R2 no change before third edge", 0, 0, 0);
        tick(1);
        expect_st("R12 supply release enters gate-low wait", 0, 0, 4);
        tick(HSD);
        expect_st("R9 still in high delay", 0, 0, 5);
        tick(1);
        expect_st("R9 high side rises after HS_DLY", 1, 0, 6);
        expect_st("R13 PWM high gives high side", 1, 0, 6);

        // high to low with node still high
        pwm = 1'b0; swl = 1'b0;
        tick(3);
        expect_st("R6 high side off, waiting for node", 0, 0, 1);
        tick(20);
        expect_st("R6 node high keeps low side off", 0, 0, 1);
        swl = 1'b1;
        tick(2 + LSD);
        expect_st("R7 still in low delay", 0, 0, 2);
        tick(1);
        expect_st("R7 low side rises after LS_DLY", 0, 1, 3);
        expect_st("R13 PWM low gives low side", 0, 1, 3);
        lgl = 1'b0;

        // low to high, then abort in the high delay
        pwm = 1'b1;
        tick(3);
        expect_st("R8 low side off, waiting for gate-low", 0, 0, 4);
        tick(10);
        expect_st("R8 gate-low false keeps high side off", 0, 0, 4);
        lgl = 1'b1;
        tick(3);
        expect_st("R9 entered high delay", 0, 0, 5);
        pwm = 1'b0;
        tick(3);
        expect_st("R10 reversal aborts high delay", 0, 0, 1);
        tick(1);
        expect_st("R10 new direction proceeds to low delay", 0, 0, 2);
        tick(LSD - 1);
        expect_st("R10 high side never rose", 0, 0, 2);
        tick(1);
        expect_st("R10 low side after full delay", 0, 1, 3);
        lgl = 1'b0;

        // enable low with PWM high
        en = 1'b0; pwm = 1'b1;
        tick(3);
        expect_st("R3 enable low forces off", 0, 0, 0);
        tick(20);
        expect_st("R3 PWM high ignored while disabled", 0, 0, 0);
        lgl = 1'b1;
        en = 1'b1;
        tick(3);
        expect_st("R12 enable release enters gate-low wait", 0, 0, 4);
        tick(HSD);
        expect_st("R12 delay still running", 0, 0, 5);
        tick(1);
        expect_st("R12 high side after full delay", 1, 0, 6);

        // over-temperature
        hot = 1'b1;
        tick(3);
        expect_st("R5 over-temperature forces off", 0, 0, 0);
        pwm = 1'b0; swl = 1'b1;
        tick(10);
        expect_st("R5 held off while hot", 0, 0, 0);
        hot = 1'b0;
        tick(3);
        expect_st("R5 release enters node wait", 0, 0, 1);
        tick(LSD);
        expect_st("R7 delay after hot release", 0, 0, 2);
        tick(1);
        expect_st("R7 low side after hot release", 0, 1, 3);

        // supply drop while low side on
        sok = 1'b0;
        tick(3);
        expect_st("R4 supply drop forces off", 0, 0, 0);

        n_chk++;
        if (both_seen) begin
            n_bad++;
            $display("FAIL R11: actual both gates high seen expected never");
        end
        done = 1'b1;
        finish_run();
    end
endmodule